// File: doc/BRIEF.md
# Brake Fault Input Monitor

This block sits in front of a PWM output stage and decides when the stage must be forced into a safe state. It watches two fault pins, called path A and path B. Each pin passes through an optional inversion and a two-stage synchronizer. A glitch filter follows, and it can be bypassed. At the end a detector looks for a falling level. A falling level on a path whose enable is set records a sticky fault flag. On path A it also records a lock flag.

Path A has three more fault sources: on-chip comparator outputs, each with its own enable. Path B has one more source: a low-supply detect signal with its own enable. Software clears each flag with a one-cycle clear pulse. Two live status outputs tell the output stage which brake state is active. A single interrupt request is raised while either fault flag is set and the interrupt enable is on. The override of the PWM outputs is not part of this block.

Top module: `brake_fault_monitor`

## Requirements
- R1: After reset, flag_a, flag_b, lock_a, brake_a_active, brake_b_active and irq are all 0.
- R2: The level seen by a path is the pin XOR its invert input. With the invert input at 1, a rising pin is what records the fault.
- R3: With the filter on, a new level is taken only when it is present in 3 consecutive filter samples. The sample interval is 2^sel clock cycles (sel 0..3 gives 1, 2, 4 or 8 cycles). A low pulse that covers at most 2 samples sets no flag.
- R4: With the filter bypass input at 1, a single-cycle low level on a pin is enough. The flag goes high at the 3rd rising clock edge after the pin falls.
- R5: A recognised fall on path A sets flag_a, and one on path B sets flag_b. Each flag stays set until its clear pulse. A new fault in the same cycle as the clear leaves the flag set.
- R6: Every path A fault also sets lock_a. Only clr_lock clears lock_a; clr_flag_a leaves it unchanged.
- R7: A comparator output bit at 1 with its cmp_en bit at 1 sets flag_a and lock_a in the next cycle. A comparator output whose enable is 0 has no effect.
- R8: lvd_in at 1 with lvd_en at 1 sets flag_b and leaves flag_a unchanged.
- R9: With en_a at 0, neither the pin nor the comparators can set flag_a.
- R10: brake_a_active is flag_a OR lock_a. brake_b_active equals flag_b.
- R11: irq is irq_en AND (flag_a OR flag_b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_pin_a | input | 1 | Fault pin, path A |
| brk_pin_b | input | 1 | Fault pin, path B |
| inv_a | input | 1 | Invert path A pin |
| inv_b | input | 1 | Invert path B pin |
| filt_sel_a | input | 2 | Filter sample interval select, path A |
| filt_sel_b | input | 2 | Filter sample interval select, path B |
| filt_off_a | input | 1 | Bypass filter, path A |
| filt_off_b | input | 1 | Bypass filter, path B |
| en_a | input | 1 | Enable path A faults |
| en_b | input | 1 | Enable path B faults |
| cmp_out | input | 3 | Comparator outputs, active high |
| cmp_en | input | 3 | Per-comparator enable into path A |
| lvd_in | input | 1 | Low-supply detect, active high |
| lvd_en | input | 1 | Enable low-supply detect into path B |
| irq_en | input | 1 | Interrupt enable |
| clr_flag_a | input | 1 | Clear pulse for flag_a |
| clr_flag_b | input | 1 | Clear pulse for flag_b |
| clr_lock | input | 1 | Clear pulse for lock_a |
| flag_a | output | 1 | Sticky path A fault flag |
| flag_b | output | 1 | Sticky path B fault flag |
| lock_a | output | 1 | Path A lock flag |
| brake_a_active | output | 1 | Brake A state active |
| brake_b_active | output | 1 | Brake B state active |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives pulses whose lengths sit just inside and just outside the three-sample rule at several sample intervals. A filter that counts samples wrongly, or that samples on the wrong interval, would accept the short pulses or reject the long ones. In bypass mode it counts the exact edge at which the flag rises, so an extra or missing pipeline stage shows up. It clears flag_a while leaving lock_a set, and drives a fault in the same cycle as a clear. A design that tied the lock to the flag, or let the clear win, would drop the brake state too early. It also drives comparator and low-supply sources with their enables off, and with the path enable off, where any leakage would set a flag.

// File: rtl/brake_pkg.sv
package brake_pkg;

  // Number of fault paths handled by the monitor
  localparam int NUM_PATHS = 2;

  // True when the prescaler count lands on a sample point for the given select.
  // Sample interval is 2^(sel*step) cycles.
  function automatic logic filt_tick(input logic [31:0] cnt, input logic [1:0] sel,
                                     input int step);
    int          sh;
    logic [31:0] mask;
    sh   = int'(sel) * step;
    mask = (32'd1 << sh) - 32'd1;
    return (cnt & mask) == 32'd0;
  endfunction

  // Next value of a sticky flag: a set wins over a clear in the same cycle
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/brake_glitch_filter.sv
module brake_glitch_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int HW = DEPTH - 1;

  logic [HW-1:0]    hist;
  logic [DEPTH-1:0] window;
  logic             all_hi, all_lo;

  assign window = {hist, din};
  assign all_hi = &window;
  assign all_lo = ~|window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
      dout <= 1'b1;
    end else if (tick) begin
      hist <= window[HW-1:0];
      if (all_hi)      dout <= 1'b1;
      else if (all_lo) dout <= 1'b0;
    end
  end

  // R3: output only moves on a sample point
  assert_filter_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout));

  // R3: a new output level is always the level that was just sampled
  assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> (dout == $past(din)));

endmodule

// File: rtl/brake_input_path.sv
module brake_input_path #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  input  logic tick,
  input  logic filt_off,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_lvl;
  logic                   filt_lvl;
  logic                   det_lvl;
  logic                   prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin ^ inv};
  end
  assign sync_lvl = sync_q[SYNC_STAGES-1];

  brake_glitch_filter #(.DEPTH(FILT_DEPTH)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .din  (sync_lvl),
    .dout (filt_lvl)
  );

  assign det_lvl = filt_off ? sync_lvl : filt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b1;
    else        prev_lvl <= det_lvl;
  end

  assign fall = prev_lvl & ~det_lvl;

  // R4: in bypass, a detected fall comes from a synchronized low
  assert_bypass_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_off && fall) |-> (sync_q[SYNC_STAGES-1] == 1'b0));

endmodule

// File: rtl/brake_fault_monitor.sv
module brake_fault_monitor
  import brake_pkg::*;
#(
  parameter int NUM_CMP     = 3,
  parameter int FILT_STEP   = 1,
  parameter int FILT_DEPTH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               brk_pin_a,
  input  logic               brk_pin_b,
  input  logic               inv_a,
  input  logic               inv_b,
  input  logic [1:0]         filt_sel_a,
  input  logic [1:0]         filt_sel_b,
  input  logic               filt_off_a,
  input  logic               filt_off_b,
  input  logic               en_a,
  input  logic               en_b,
  input  logic [NUM_CMP-1:0] cmp_out,
  input  logic [NUM_CMP-1:0] cmp_en,
  input  logic               lvd_in,
  input  logic               lvd_en,
  input  logic               irq_en,
  input  logic               clr_flag_a,
  input  logic               clr_flag_b,
  input  logic               clr_lock,
  output logic               flag_a,
  output logic               flag_b,
  output logic               lock_a,
  output logic               brake_a_active,
  output logic               brake_b_active,
  output logic               irq
);
  localparam int PRE_W = 3 * FILT_STEP;

  logic [PRE_W-1:0]     pre_cnt;
  logic [NUM_PATHS-1:0] pin_v, inv_v, off_v, tick_v, fall_v;
  logic [1:0]           sel_v [NUM_PATHS];
  logic                 cmp_hit, lvd_hit;
  logic                 evt_a, evt_b;
  logic                 flag_a_q, flag_b_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  assign pin_v    = {brk_pin_b, brk_pin_a};
  assign inv_v    = {inv_b, inv_a};
  assign off_v    = {filt_off_b, filt_off_a};
  assign sel_v[0] = filt_sel_a;
  assign sel_v[1] = filt_sel_b;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    assign tick_v[g] = filt_tick({{(32-PRE_W){1'b0}}, pre_cnt}, sel_v[g], FILT_STEP);

    brake_input_path #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_DEPTH (FILT_DEPTH)
    ) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_v[g]),
      .inv     (inv_v[g]),
      .tick    (tick_v[g]),
      .filt_off(off_v[g]),
      .fall    (fall_v[g])
    );
  end

  assign cmp_hit = |(cmp_out & cmp_en);
  assign lvd_hit = lvd_in & lvd_en;
  assign evt_a   = en_a & (fall_v[0] | cmp_hit);
  assign evt_b   = en_b & (fall_v[1] | lvd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      flag_a_q <= sticky_next(flag_a_q, evt_a, clr_flag_a);
      flag_b_q <= sticky_next(flag_b_q, evt_b, clr_flag_b);
      lock_q   <= sticky_next(lock_q,   evt_a, clr_lock);
    end
  end

  assign flag_a         = flag_a_q;
  assign flag_b         = flag_b_q;
  assign lock_a         = lock_q;
  assign brake_a_active = flag_a_q | lock_q;
  assign brake_b_active = flag_b_q;
  assign irq            = irq_en & (flag_a_q | flag_b_q);

  // R5: flags hold without a clear pulse
  assert_flag_a_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !clr_flag_a) |=> flag_a);
  assert_flag_b_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !clr_flag_b) |=> flag_b);

  // R6: lock holds without its own clear pulse
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_a && !clr_lock) |=> lock_a);

  // R6: the lock only rises together with a path A fault
  assert_lock_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_a) |-> flag_a);

  // R9: a flag can only rise while its path was enabled
  assert_flag_a_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(en_a));
  assert_flag_b_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(en_b));

endmodule

// File: tb/test_brake_fault_monitor.sv
module test_brake_fault_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       brk_pin_a = 1'b1, brk_pin_b = 1'b1;
  logic       inv_a = 1'b0, inv_b = 1'b0;
  logic [1:0] filt_sel_a = 2'd0, filt_sel_b = 2'd0;
  logic       filt_off_a = 1'b0, filt_off_b = 1'b0;
  logic       en_a = 1'b1, en_b = 1'b1;
  logic [2:0] cmp_out = 3'b000, cmp_en = 3'b000;
  logic       lvd_in = 1'b0, lvd_en = 1'b0, irq_en = 1'b0;
  logic       clr_flag_a = 1'b0, clr_flag_b = 1'b0, clr_lock = 1'b0;
  logic       flag_a, flag_b, lock_a, brake_a_active, brake_b_active, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  brake_fault_monitor i_brake_fault_monitor (
    .clk(clk), .rst_n(rst_n),
    .brk_pin_a(brk_pin_a), .brk_pin_b(brk_pin_b),
    .inv_a(inv_a), .inv_b(inv_b),
    .filt_sel_a(filt_sel_a), .filt_sel_b(filt_sel_b),
    .filt_off_a(filt_off_a), .filt_off_b(filt_off_b),
    .en_a(en_a), .en_b(en_b),
    .cmp_out(cmp_out), .cmp_en(cmp_en),
    .lvd_in(lvd_in), .lvd_en(lvd_en), .irq_en(irq_en),
    .clr_flag_a(clr_flag_a), .clr_flag_b(clr_flag_b), .clr_lock(clr_lock),
    .flag_a(flag_a), .flag_b(flag_b), .lock_a(lock_a),
    .brake_a_active(brake_a_active), .brake_b_active(brake_b_active), .irq(irq)
  );

  typedef struct packed {
    logic       inv;
    logic       off;
    logic [1:0] sel;
    logic [7:0] len;
    logic       exp;
  } vec_t;

  // effective-low pulse on path A; expected flag_a afterwards
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 2'd0, 8'd1,  1'b1},
    '{1'b0, 1'b0, 2'd0, 8'd2,  1'b0},
    '{1'b0, 1'b0, 2'd0, 8'd4,  1'b1},
    '{1'b1, 1'b0, 2'd0, 8'd4,  1'b1},
    '{1'b0, 1'b0, 2'd1, 8'd4,  1'b0},
    '{1'b0, 1'b0, 2'd1, 8'd8,  1'b1},
    '{1'b0, 1'b0, 2'd3, 8'd12, 1'b0},
    '{1'b0, 1'b0, 2'd3, 8'd30, 1'b1},
    '{1'b1, 1'b1, 2'd0, 8'd1,  1'b1},
    '{1'b1, 1'b0, 2'd2, 8'd6,  1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_flag_a = 1'b1; clr_flag_b = 1'b1; clr_lock = 1'b1;
    cyc(1);
    clr_flag_a = 1'b0; clr_flag_b = 1'b0; clr_lock = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 flag_a", flag_a, 1'b0);
    chk("R1 flag_b", flag_b, 1'b0);
    chk("R1 lock_a", lock_a, 1'b0);
    chk("R1 brake_a_active", brake_a_active, 1'b0);
    chk("R1 brake_b_active", brake_b_active, 1'b0);
    chk("R1 irq", irq, 1'b0);

    // table walk: R2 / R3 / R4 pulse shapes on path A
    foreach (VECS[i]) begin
      string tag;
      tag = VECS[i].off ? "R4" : (VECS[i].inv ? "R2" : "R3");
      inv_a = VECS[i].inv; brk_pin_a = ~VECS[i].inv;
      filt_off_a = VECS[i].off; filt_sel_a = VECS[i].sel;
      cyc(40);
      clear_all();
      brk_pin_a = VECS[i].inv;
      cyc(int'(VECS[i].len));
      brk_pin_a = ~VECS[i].inv;
      cyc(60);
      chk($sformatf("%s row %0d flag_a", tag, i), flag_a, VECS[i].exp);
      clear_all();
    end
    inv_a = 1'b0; brk_pin_a = 1'b1; filt_off_a = 1'b1; filt_sel_a = 2'd0;
    cyc(10);

    // R4 exact latency in bypass
    brk_pin_a = 1'b0;
    cyc(2);
    chk("R4 flag_a after 2 edges", flag_a, 1'b0);
    cyc(1);
    chk("R4 flag_a after 3 edges", flag_a, 1'b1);
    brk_pin_a = 1'b1;
    cyc(5);
    clear_all();

    // R9 path disabled
    en_a = 1'b0;
    brk_pin_a = 1'b0; cyc(3); brk_pin_a = 1'b1;
    cmp_en = 3'b111; cmp_out = 3'b111; cyc(1); cmp_out = 3'b000;
    cyc(10);
    chk("R9 flag_a with en_a off", flag_a, 1'b0);
    en_a = 1'b1;

    // R7 comparators
    cmp_en = 3'b010; cmp_out = 3'b001; cyc(1); cmp_out = 3'b000; cyc(2);
    chk("R7 disabled comparator flag_a", flag_a, 1'b0);
    cmp_out = 3'b010; cyc(1); cmp_out = 3'b000;
    chk("R7 enabled comparator flag_a", flag_a, 1'b1);
    chk("R7 enabled comparator lock_a", lock_a, 1'b1);

    // R6 / R10 lock outlives the flag
    clr_flag_a = 1'b1; cyc(1); clr_flag_a = 1'b0; cyc(1);
    chk("R6 lock_a after flag clear", lock_a, 1'b1);
    chk("R10 brake_a_active from lock", brake_a_active, 1'b1);
    clr_lock = 1'b1; cyc(1); clr_lock = 1'b0; cyc(1);
    chk("R6 lock_a after lock clear", lock_a, 1'b0);
    chk("R10 brake_a_active released", brake_a_active, 1'b0);

    // R8 low-supply source and R11 interrupt
    lvd_en = 1'b1; lvd_in = 1'b1; cyc(1); lvd_in = 1'b0; cyc(1);
    chk("R8 flag_b", flag_b, 1'b1);
    chk("R8 flag_a untouched", flag_a, 1'b0);
    chk("R10 brake_b_active", brake_b_active, 1'b1);
    chk("R11 irq masked", irq, 1'b0);
    irq_en = 1'b1; cyc(1);
    chk("R11 irq enabled", irq, 1'b1);
    cyc(20);
    chk("R5 flag_b sticky", flag_b, 1'b1);
    clr_flag_b = 1'b1; cyc(1); clr_flag_b = 1'b0; cyc(1);
    chk("R10 brake_b_active after clear", brake_b_active, 1'b0);
    chk("R11 irq after clear", irq, 1'b0);

    // R5 set wins over clear in the same cycle
    lvd_in = 1'b1; clr_flag_b = 1'b1; cyc(1);
    lvd_in = 1'b0; clr_flag_b = 1'b0; cyc(1);
    chk("R5 set beats clear", flag_b, 1'b1);
    clear_all();
    lvd_en = 1'b0;

    // R5 path B pin fall sets flag_b only
    filt_off_b = 1'b1;
    brk_pin_b = 1'b0; cyc(1); brk_pin_b = 1'b1; cyc(5);
    chk("R5 path B flag_b", flag_b, 1'b1);
    chk("R5 path B lock_a untouched", lock_a, 1'b0);
    clear_all();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule